// File: doc/BRIEF.md
# Addressed Multi-Drop Configuration Port

This block receives configuration for a two-channel voice coder over a write-only, three-wire serial link: a clock, a data line and an active-low select. Up to sixty-four such blocks may hang on one set of wires. Each one is told apart by a six-bit address strapped on its pins. A write opens with a leading byte that names the device and the channel (X or Y). After it come one or three bytes, which fill that channel's control register, its input timeslot register and its output timeslot register, in that order. All three serial inputs are synchronised into the block's own clock, and every finished byte goes into its register at once.

A mode pin can switch the serial port off. In that fixed mode the coding direction, the companding law and the idle state of each channel come straight from pins, and every timeslot reads as zero. The block also produces the power-on defaults, clears the algorithm-reset request by itself after a set number of clock cycles, and raises a standby flag while both channels are idle.

Top module: `mdcfg_port`

## Requirements
- R1: A write starts when `csn` goes low and ends when it goes high. `sdi` is taken on each rising edge of `sclk` while `csn` is low, and each byte arrives least significant bit first.
- R2: In the leading byte, bits 5:0 must equal `addr_pins` and bit 7 must be 0 for the write to be accepted. Bit 6 picks the channel: 1 = X, 0 = Y.
- R3: If the leading byte is not accepted, every later byte of that write leaves all configuration outputs unchanged.
- R4: After an accepted leading byte, byte 2 goes to the control register, byte 3 to the input timeslot and byte 4 to the output timeslot. A two-byte write changes only the control register. A fifth or later byte changes nothing.
- R5: Control byte fields: bit 5 = idle, bit 4 = algorithm reset, bit 3 = bypass, bit 2 = law (1 = mu-law, 0 = A-law), bit 0 = direction (1 = compress, 0 = expand). Bits 7, 6 and 1 are not stored.
- R6: A timeslot byte stores bits 5:0. Bits 7:6 are dropped.
- R7: If `csn` rises while a byte is only partly shifted in, that byte is discarded. The next write starts again from a leading byte.
- R8: After reset, in serial mode, both channels show idle = 1. Every other control bit and every timeslot is 0.
- R9: Writing a control byte with the algorithm-reset bit set raises that channel's `alg_reset`. The flag stays high for exactly `ALRST_CYC` clock cycles and then clears by itself.
- R10: `standby` is high exactly when both channels' `idle` outputs are high.
- R11: With `serial_mode` low: X compress = `addr_pins[0]`, X mu-law = `addr_pins[2]`, Y compress = `addr_pins[3]`, Y mu-law = `addr_pins[5]`, X idle = `csn`, Y idle = `sdi`. Bypass, algorithm reset and all timeslots are 0.
- R12: While `serial_mode` is low, the serial registers are held cleared. On return to serial mode, every control bit (idle included) and every timeslot reads 0 until the next write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| serial_mode | input | 1 | 1 = serial port active, 0 = fixed pin mode |
| addr_pins | input | 6 | Strapped device address; also the fixed-mode pins |
| sclk | input | 1 | Serial clock |
| sdi | input | 1 | Serial data; Y idle in fixed mode |
| csn | input | 1 | Serial select, active low; X idle in fixed mode |
| idle | output | 2 | Channel idle, [1] = X, [0] = Y |
| alg_reset | output | 2 | Algorithm reset request per channel |
| bypass | output | 2 | Bypass per channel |
| mulaw | output | 2 | 1 = mu-law, 0 = A-law per channel |
| compress | output | 2 | 1 = compress, 0 = expand per channel |
| in_slot_x | output | 6 | X input timeslot |
| out_slot_x | output | 6 | X output timeslot |
| in_slot_y | output | 6 | Y input timeslot |
| out_slot_y | output | 6 | Y output timeslot |
| standby | output | 1 | Both channels idle |

## Verification
The bench builds the block with two synchroniser stages and `ALRST_CYC` = 40. This makes the self-clear window short enough to see both the set and the cleared state inside one write-to-write gap. All sixty-four leading-byte addresses are sent once against a matching strap and once against a strap that differs in one bit, so every address bit is seen both to accept and to reject a write. In fixed mode all sixty-four pin patterns, combined with all four select/data pairs, are swept. That covers the whole pin map.

// File: rtl/mdcfg_pkg.sv
package mdcfg_pkg;
    localparam int ADDR_W = 6;
    localparam int TS_W   = 6;
    localparam int NCH    = 2;
    localparam int BYTE_W = 8;

    localparam int CH_Y = 0;
    localparam int CH_X = 1;

    // control byte bit positions
    localparam int CB_IDLE  = 5;
    localparam int CB_ALRST = 4;
    localparam int CB_BYP   = 3;
    localparam int CB_LAW   = 2;
    localparam int CB_DIR   = 0;

    // leading byte bit positions
    localparam int AB_RSV = 7;
    localparam int AB_SEL = 6;

    typedef enum logic [2:0] {
        SLOT_ADDR = 3'd0,
        SLOT_CTL  = 3'd1,
        SLOT_ITS  = 3'd2,
        SLOT_OTS  = 3'd3,
        SLOT_OVER = 3'd4
    } slot_e;

    typedef struct packed {
        logic idle;
        logic alrst;
        logic bypass;
        logic mulaw;
        logic compress;
    } ctl_t;

    typedef struct packed {
        ctl_t            ctl;
        logic [TS_W-1:0] its;
        logic [TS_W-1:0] ots;
    } chan_cfg_t;

    function automatic ctl_t unpack_ctl(input logic [BYTE_W-1:0] b);
        ctl_t c;
        c.idle     = b[CB_IDLE];
        c.alrst    = b[CB_ALRST];
        c.bypass   = b[CB_BYP];
        c.mulaw    = b[CB_LAW];
        c.compress = b[CB_DIR];
        return c;
    endfunction

    function automatic chan_cfg_t cfg_after_reset();
        chan_cfg_t c;
        c = '0;
        c.ctl.idle = 1'b1;
        return c;
    endfunction

    function automatic logic addr_hit(input logic [BYTE_W-1:0] b,
                                      input logic [ADDR_W-1:0] pins);
        return (b[AB_RSV] == 1'b0) && (b[ADDR_W-1:0] == pins);
    endfunction
endpackage

// File: rtl/mdcfg_rx.sv
module mdcfg_rx
    import mdcfg_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  logic              sclk,
    input  logic              sdi,
    input  logic              csn,
    output logic              byte_stb,
    output logic [BYTE_W-1:0] byte_val,
    output slot_e             byte_slot
);
    localparam int LAST = SYNC_STAGES - 1;

    logic [SYNC_STAGES-1:0] sclk_sr, sdi_sr, csn_sr;
    logic sclk_s, sdi_s, csn_s, sclk_q, rise;
    logic [2:0]        bit_cnt;
    logic [BYTE_W-2:0] shreg;
    slot_e             slot_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_sr <= '0;
            sdi_sr  <= '0;
            csn_sr  <= '1;
        end else begin
            sclk_sr <= {sclk_sr[LAST-1:0], sclk};
            sdi_sr  <= {sdi_sr[LAST-1:0], sdi};
            csn_sr  <= {csn_sr[LAST-1:0], csn};
        end
    end

    assign sclk_s = sclk_sr[LAST];
    assign sdi_s  = sdi_sr[LAST];
    assign csn_s  = csn_sr[LAST];
    assign rise   = sclk_s && !sclk_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_q    <= 1'b0;
            bit_cnt   <= '0;
            shreg     <= '0;
            slot_cnt  <= SLOT_ADDR;
            byte_stb  <= 1'b0;
            byte_val  <= '0;
            byte_slot <= SLOT_ADDR;
        end else begin
            sclk_q   <= sclk_s;
            byte_stb <= 1'b0;
            if (!enable || csn_s) begin
                bit_cnt  <= '0;
                slot_cnt <= SLOT_ADDR;
            end else if (rise) begin
                shreg   <= {sdi_s, shreg[BYTE_W-2:1]};
                bit_cnt <= bit_cnt + 3'd1;
                if (bit_cnt == 3'd7) begin
                    byte_stb  <= 1'b1;
                    byte_val  <= {sdi_s, shreg};
                    byte_slot <= slot_cnt;
                    if (slot_cnt != SLOT_OVER)
                        slot_cnt <= slot_e'(slot_cnt + 3'd1);
                end
            end
        end
    end
endmodule

// File: rtl/mdcfg_bank.sv
module mdcfg_bank
    import mdcfg_pkg::*;
#(
    parameter int ALRST_CYC = 64
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  clear,
    input  logic                  byte_stb,
    input  logic [BYTE_W-1:0]     byte_val,
    input  slot_e                 byte_slot,
    input  logic [ADDR_W-1:0]     addr_pins,
    output chan_cfg_t [NCH-1:0]   cfg
);
    localparam int CW = $clog2(ALRST_CYC + 1);

    logic hit_q, sel_q;
    ctl_t nc;

    assign nc = unpack_ctl(byte_val);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            hit_q <= 1'b0;
            sel_q <= 1'b0;
        end else if (byte_stb && byte_slot == SLOT_ADDR) begin
            hit_q <= addr_hit(byte_val, addr_pins);
            sel_q <= byte_val[AB_SEL];
        end
    end

    for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
        chan_cfg_t      r;
        logic [CW-1:0]  cnt;
        logic           mine, wr_ctl, wr_its, wr_ots, start;

        assign mine   = byte_stb && hit_q && (sel_q == (ch == CH_X));
        assign wr_ctl = mine && byte_slot == SLOT_CTL;
        assign wr_its = mine && byte_slot == SLOT_ITS;
        assign wr_ots = mine && byte_slot == SLOT_OTS;
        assign start  = wr_ctl && nc.alrst && !r.ctl.alrst;

        always_ff @(posedge clk) begin
            if (rst) begin
                r   <= cfg_after_reset();
                cnt <= '0;
            end else if (clear) begin
                r   <= '0;
                cnt <= '0;
            end else begin
                if (wr_ctl) begin
                    r.ctl.idle     <= nc.idle;
                    r.ctl.bypass   <= nc.bypass;
                    r.ctl.mulaw    <= nc.mulaw;
                    r.ctl.compress <= nc.compress;
                end
                if (start) begin
                    r.ctl.alrst <= 1'b1;
                    cnt         <= CW'(ALRST_CYC - 1);
                end else if (r.ctl.alrst) begin
                    if (cnt == '0) r.ctl.alrst <= 1'b0;
                    else           cnt <= cnt - 1'b1;
                end
                if (wr_its) r.its <= byte_val[TS_W-1:0];
                if (wr_ots) r.ots <= byte_val[TS_W-1:0];
            end
        end

        assign cfg[ch] = r;
    end
endmodule

// File: rtl/mdcfg_pinmap.sv
module mdcfg_pinmap
    import mdcfg_pkg::*;
(
    input  logic [ADDR_W-1:0]   addr_pins,
    input  logic                sdi,
    input  logic                csn,
    output chan_cfg_t [NCH-1:0] cfg
);
    always_comb begin
        cfg = '0;
        cfg[CH_X].ctl.compress = addr_pins[0];
        cfg[CH_X].ctl.mulaw    = addr_pins[2];
        cfg[CH_Y].ctl.compress = addr_pins[3];
        cfg[CH_Y].ctl.mulaw    = addr_pins[5];
        cfg[CH_X].ctl.idle     = csn;
        cfg[CH_Y].ctl.idle     = sdi;
    end
endmodule

// File: rtl/mdcfg_port.sv
module mdcfg_port
    import mdcfg_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int ALRST_CYC   = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              serial_mode,
    input  logic [ADDR_W-1:0] addr_pins,
    input  logic              sclk,
    input  logic              sdi,
    input  logic              csn,
    output logic [NCH-1:0]    idle,
    output logic [NCH-1:0]    alg_reset,
    output logic [NCH-1:0]    bypass,
    output logic [NCH-1:0]    mulaw,
    output logic [NCH-1:0]    compress,
    output logic [TS_W-1:0]   in_slot_x,
    output logic [TS_W-1:0]   out_slot_x,
    output logic [TS_W-1:0]   in_slot_y,
    output logic [TS_W-1:0]   out_slot_y,
    output logic              standby
);
    logic              byte_stb;
    logic [BYTE_W-1:0] byte_val;
    slot_e             byte_slot;
    chan_cfg_t [NCH-1:0] reg_cfg, pin_cfg, eff_cfg;

    mdcfg_rx #(.SYNC_STAGES(SYNC_STAGES)) u_rx (
        .clk(clk), .rst(rst), .enable(serial_mode),
        .sclk(sclk), .sdi(sdi), .csn(csn),
        .byte_stb(byte_stb), .byte_val(byte_val), .byte_slot(byte_slot)
    );

    mdcfg_bank #(.ALRST_CYC(ALRST_CYC)) u_bank (
        .clk(clk), .rst(rst), .clear(!serial_mode),
        .byte_stb(byte_stb), .byte_val(byte_val), .byte_slot(byte_slot),
        .addr_pins(addr_pins), .cfg(reg_cfg)
    );

    mdcfg_pinmap u_pinmap (
        .addr_pins(addr_pins), .sdi(sdi), .csn(csn), .cfg(pin_cfg)
    );

    assign eff_cfg = serial_mode ? reg_cfg : pin_cfg;

    for (genvar ch = 0; ch < NCH; ch++) begin : g_out
        assign idle[ch]      = eff_cfg[ch].ctl.idle;
        assign alg_reset[ch] = eff_cfg[ch].ctl.alrst;
        assign bypass[ch]    = eff_cfg[ch].ctl.bypass;
        assign mulaw[ch]     = eff_cfg[ch].ctl.mulaw;
        assign compress[ch]  = eff_cfg[ch].ctl.compress;
    end

    assign in_slot_x  = eff_cfg[CH_X].its;
    assign out_slot_x = eff_cfg[CH_X].ots;
    assign in_slot_y  = eff_cfg[CH_Y].its;
    assign out_slot_y = eff_cfg[CH_Y].ots;
    assign standby    = &idle;
endmodule

// File: rtl/mdcfg_port_chk.sv
module mdcfg_port_chk
    import mdcfg_pkg::*;
#(
    parameter int ALRST_CYC = 64
) (
    input logic              clk,
    input logic              rst,
    input logic              serial_mode,
    input logic [ADDR_W-1:0] addr_pins,
    input logic              sdi,
    input logic              csn,
    input logic [NCH-1:0]    idle,
    input logic [NCH-1:0]    alg_reset,
    input logic [NCH-1:0]    bypass,
    input logic [NCH-1:0]    mulaw,
    input logic [NCH-1:0]    compress,
    input logic [TS_W-1:0]   in_slot_x,
    input logic [TS_W-1:0]   out_slot_x,
    input logic [TS_W-1:0]   in_slot_y,
    input logic [TS_W-1:0]   out_slot_y,
    input logic              standby
);
    localparam int CW = $clog2(ALRST_CYC + 2);
    logic [CW-1:0] high_run [NCH];
    logic          started;

    always_ff @(posedge clk) begin
        if (rst) started <= 1'b1;
    end

    for (genvar ch = 0; ch < NCH; ch++) begin : g_run
        always_ff @(posedge clk) begin
            if (rst || !alg_reset[ch]) high_run[ch] <= '0;
            else if (high_run[ch] <= CW'(ALRST_CYC)) high_run[ch] <= high_run[ch] + 1'b1;
        end

        // R9
        alrst_window_chk: assert property (@(posedge clk) disable iff (rst)
            high_run[ch] <= CW'(ALRST_CYC));
    end

    // R8
    reset_defaults_chk: assert property (@(posedge clk)
        started && $past(rst) && serial_mode |->
            idle == 2'b11 && alg_reset == '0 && bypass == '0 && mulaw == '0 &&
            compress == '0 && in_slot_x == '0 && out_slot_x == '0 &&
            in_slot_y == '0 && out_slot_y == '0);

    // R10
    standby_chk: assert property (@(posedge clk) disable iff (rst)
        standby == (idle == 2'b11));

    // R11
    pin_mode_chk: assert property (@(posedge clk) disable iff (rst)
        !serial_mode |->
            compress == {addr_pins[0], addr_pins[3]} &&
            mulaw == {addr_pins[2], addr_pins[5]} &&
            idle == {csn, sdi} && bypass == '0 && alg_reset == '0 &&
            in_slot_x == '0 && out_slot_y == '0);

    // R12
    pin_exit_clear_chk: assert property (@(posedge clk) disable iff (rst)
        serial_mode && !$past(serial_mode) |->
            idle == '0 && in_slot_x == '0 && in_slot_y == '0 && compress == '0);
endmodule

bind mdcfg_port mdcfg_port_chk #(.ALRST_CYC(ALRST_CYC)) u_chk (
    .clk(clk), .rst(rst), .serial_mode(serial_mode), .addr_pins(addr_pins),
    .sdi(sdi), .csn(csn), .idle(idle), .alg_reset(alg_reset), .bypass(bypass),
    .mulaw(mulaw), .compress(compress), .in_slot_x(in_slot_x),
    .out_slot_x(out_slot_x), .in_slot_y(in_slot_y), .out_slot_y(out_slot_y),
    .standby(standby)
);

// File: tb/mdcfg_port_tb.sv
module mdcfg_port_tb;
    localparam int ALRST = 40;

    logic clk = 1'b0, rst = 1'b1, serial_mode = 1'b1;
    logic [5:0] addr_pins = '0;
    logic sclk = 1'b0, sdi = 1'b0, csn = 1'b1;
    logic [1:0] idle, alg_reset, bypass, mulaw, compress;
    logic [5:0] in_slot_x, out_slot_x, in_slot_y, out_slot_y;
    logic standby;

    int errors = 0, checks = 0;
    logic [7:0] e_ctl [2];
    logic [5:0] e_its [2];
    logic [5:0] e_ots [2];

    always #10 clk = ~clk;

    mdcfg_port #(.SYNC_STAGES(2), .ALRST_CYC(ALRST)) u_dut (
        .clk(clk), .rst(rst), .serial_mode(serial_mode), .addr_pins(addr_pins),
        .sclk(sclk), .sdi(sdi), .csn(csn), .idle(idle), .alg_reset(alg_reset),
        .bypass(bypass), .mulaw(mulaw), .compress(compress),
        .in_slot_x(in_slot_x), .out_slot_x(out_slot_x),
        .in_slot_y(in_slot_y), .out_slot_y(out_slot_y), .standby(standby)
    );

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] act_ctl(input int ch);
        return {2'b00, idle[ch], alg_reset[ch], bypass[ch], mulaw[ch], 1'b0, compress[ch]};
    endfunction

    task automatic check_all(input string req);
        check(req, act_ctl(1), e_ctl[1]);
        check(req, act_ctl(0), e_ctl[0]);
        check(req, {in_slot_x, out_slot_x}, {e_its[1], e_ots[1]});
        check(req, {in_slot_y, out_slot_y}, {e_its[0], e_ots[0]});
        // R10
        check({req, "/R10"}, standby, e_ctl[1][5] & e_ctl[0][5]);
    endtask

    // R1: LSB of the first byte goes out first, one bit per sclk rise
    task automatic send(input logic [39:0] d, input int nbits);
        csn = 1'b0;
        wclk(4);
        for (int i = 0; i < nbits; i++) begin
            sdi = d[i];
            wclk(4);
            sclk = 1'b1;
            wclk(4);
            sclk = 1'b0;
        end
        wclk(4);
        csn = 1'b1;
        wclk(12);
    endtask

    initial begin
        wclk(150000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [7:0] a0, c, ti, to;
        wclk(3);
        rst = 1'b0;
        wclk(2);
        for (int ch = 0; ch < 2; ch++) begin
            e_ctl[ch] = 8'h20; e_its[ch] = '0; e_ots[ch] = '0;
        end
        check_all("R8 reset");

        // R2 R4 R5 R6: matching writes over every address
        for (int a = 0; a < 64; a++) begin
            logic [5:0] av = 6'(a);
            int ch = a % 2;
            addr_pins = av;
            a0 = {1'b0, 1'(ch), av};
            c  = {2'b11, av[3], 1'b0, av[2], av[4], 1'b1, av[5]};
            ti = {2'b10, ~av};
            to = {2'b01, av + 6'd7};
            if (av[1]) begin
                send({8'h00, to, ti, c, a0}, 32);
                e_its[ch] = ti[5:0]; e_ots[ch] = to[5:0];
            end else begin
                send({24'h0, c, a0}, 16);
            end
            e_ctl[ch] = c & 8'h2D;
            check_all("R2/R4/R5/R6 match");
        end

        // R3: one strap bit differs
        for (int a = 0; a < 64; a++) begin
            logic [5:0] av = 6'(a);
            addr_pins = av ^ (6'd1 << (a % 6));
            a0 = {1'b0, 1'(a % 2), av};
            send({8'h00, 8'h15, 8'h2A, 8'h09, a0}, 32);
            check_all("R3 mismatch");
        end

        // R2: reserved bit 7 set in leading byte
        addr_pins = 6'd5;
        send({8'h00, 8'h3F, 8'h3F, 8'h0D, {2'b11, 6'd5}}, 32);
        check_all("R2 bit7");

        // R7: third byte cut after 3 bits
        send({8'h00, 8'h00, 8'h07, 8'h08, {2'b01, 6'd5}}, 19);
        e_ctl[1] = 8'h08;
        check_all("R7 partial");

        // R4: fifth byte ignored
        send({8'h3F, 8'h11, 8'h22, 8'h05, {2'b00, 6'd5}}, 40);
        e_ctl[0] = 8'h05; e_its[0] = 6'h22; e_ots[0] = 6'h11;
        check_all("R4 extra");

        // R10: standby follows both idles
        send({24'h0, 8'h20, {2'b01, 6'd5}}, 16);
        send({24'h0, 8'h20, {2'b00, 6'd5}}, 16);
        e_ctl[1] = 8'h20; e_ctl[0] = 8'h20;
        check_all("R10 both idle");
        send({24'h0, 8'h04, {2'b00, 6'd5}}, 16);
        e_ctl[0] = 8'h04;
        check_all("R10 one active");

        // R9: algorithm reset self-clears
        send({24'h0, 8'h10, {2'b01, 6'd5}}, 16);
        check("R9 set", alg_reset, 2'b10);
        check("R9 others", act_ctl(1), 8'h10);
        wclk(ALRST);
        check("R9 cleared", alg_reset, 2'b00);
        e_ctl[1] = 8'h00;
        check_all("R9 after");

        // R11: fixed pin mode, full sweep
        serial_mode = 1'b0;
        for (int p = 0; p < 64; p++) begin
            for (int k = 0; k < 4; k++) begin
                logic [5:0] pv = 6'(p);
                addr_pins = pv;
                csn = k[0];
                sdi = k[1];
                wclk(2);
                check("R11 compress", compress, {pv[0], pv[3]});
                check("R11 law", mulaw, {pv[2], pv[5]});
                check("R11 idle", {idle, standby}, {k[0], k[1], k[0] & k[1]});
                check("R11 zero", {bypass, alg_reset, in_slot_x, out_slot_x, in_slot_y, out_slot_y}, '0);
            end
        end

        // R12: back to serial mode, registers cleared
        csn = 1'b1;
        sdi = 1'b0;
        addr_pins = 6'd9;
        wclk(2);
        serial_mode = 1'b1;
        wclk(2);
        for (int ch = 0; ch < 2; ch++) begin
            e_ctl[ch] = 8'h00; e_its[ch] = '0; e_ots[ch] = '0;
        end
        check_all("R12 exit");
        send({8'h00, 8'h2C, 8'h13, 8'h0C, {2'b01, 6'd9}}, 32);
        e_ctl[1] = 8'h0C; e_its[1] = 6'h13; e_ots[1] = 6'h2C;
        check_all("R12 write after");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule